// File: doc/BRIEF.md
# Task Register Load Sequencer

This block carries out the privileged load of the task register from a 16-bit selector. It first checks the caller's privilege and the selector itself, then reads the selected descriptor from the global descriptor table through a memory port. It checks the descriptor's kind and presence, and sets the descriptor's busy flag by rewriting it while the memory lock is held. Only after that write has been accepted does it copy the selector, base and limit into the task register. No task switch follows. In 64-bit mode the descriptor is 16 bytes wide and a second word is read to supply the upper 32 bits of the base.

A failed load produces exactly one fault report. The report is a fault kind plus an error code, and it comes from the first check that fails. The checks run in this order: privilege, null selector, table bound and table kind, descriptor kind, presence.

The controller has seven named states:

- `ST_IDLE` waits for `start`. If a selector check fails it goes to `ST_FAULT`; otherwise it goes to `ST_RD_LO`.
- `ST_RD_LO` reads the low descriptor word. On `mem_ack` it goes to `ST_RD_HI` in 64-bit mode and to `ST_EVAL` otherwise.
- `ST_RD_HI` reads the high word and goes to `ST_EVAL` on `mem_ack`.
- `ST_EVAL` goes to `ST_FAULT` if the descriptor is rejected and to `ST_WRITE` otherwise.
- `ST_WRITE` writes the busy-marked word back and goes to `ST_DONE` on `mem_ack`.
- `ST_DONE` and `ST_FAULT` each last one cycle and return to `ST_IDLE`.

Top module: `trl_loader`

## Requirements
- R1: After reset, `done`, `fault`, `mem_req`, `mem_we` and `mem_lock` are low, and `tr_sel`, `tr_base` and `tr_limit` are zero.
- R2: A start with `cpl` other than 0 ends in a fault of kind 1 (general protection, code 0) and makes no memory request. This check wins over every other check.
- R3: A selector whose bits 15:2 are all zero is a null selector. Whatever its low two bits hold, it ends in a fault of kind 1 with code 0 and makes no memory request.
- R4: A selector with bit 2 set (local table) ends in a fault of kind 2 (general protection, selector code) and makes no memory request. So does a selector whose last descriptor byte lies beyond `gdt_limit`. That last byte is at offset `sel[15:3]*8 + 7` in legacy mode and `sel[15:3]*8 + 15` in 64-bit mode. The selector code is `{sel[15:2],2'b00}`.
- R5: The descriptor is accepted only if bit 44 is 0 and bits 43:40 hold 9, or hold 1 outside 64-bit mode. Any other descriptor, including the busy values 3 and 11, ends in a fault of kind 2 with the selector code, and the descriptor in memory stays unchanged.
- R6: An accepted descriptor whose present bit 47 is 0 ends in a fault of kind 3 (not present, selector code), and the descriptor in memory stays unchanged.
- R7: `mem_lock` is high from the first descriptor read through the write-back, and a write happens only under the lock. The written word is the low descriptor word as read, with bit 41 set (type 1 becomes 3, type 9 becomes 11). A request holds its address until it is acknowledged.
- R8: The descriptor's low word is read at `gdt_base + sel[15:3]*8`. In 64-bit mode a second word is read at that address plus 8, and its bits 31:0 become base bits 63:32; otherwise base bits 63:32 are zero. Base bits 31:0 come from low-word bits 63:56 and 39:16.
- R9: On success, `done` pulses for one cycle, after the write has been acknowledged. At that point `tr_sel` holds the selector exactly as given and `tr_base` holds the base. `tr_limit` holds the 20-bit limit (low-word bits 51:48 and 15:0); when bit 55 is set, the limit is shifted left by 12 and its low 12 bits are filled with ones.
- R10: On a fault, `fault` pulses for one cycle with `fault_kind` and `err_code` valid and the lock released. The task register keeps its previous contents, and `done` and `fault` are never high together.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| start | input | 1 | Begin a load; accepted only in the idle state |
| sel_in | input | 16 | Selector to load |
| cpl | input | 2 | Current privilege level |
| long_mode | input | 1 | 64-bit mode: use the 16-byte descriptor |
| gdt_base | input | ADDR_W | Global table base address |
| gdt_limit | input | TLIM_W | Global table limit in bytes |
| mem_req | output | 1 | Memory request, held until acknowledged |
| mem_we | output | 1 | Request is a write |
| mem_lock | output | 1 | Bus lock for the read-modify-write |
| mem_addr | output | ADDR_W | Byte address of the 8-byte word |
| mem_wdata | output | 64 | Write data |
| mem_rdata | input | 64 | Read data, valid with `mem_ack` |
| mem_ack | input | 1 | Request accepted / read data valid |
| done | output | 1 | One-cycle pulse on a successful load |
| fault | output | 1 | One-cycle pulse on a failed load |
| fault_kind | output | 2 | 1 = GP code 0, 2 = GP selector, 3 = not present |
| err_code | output | 16 | Error code for the fault |
| tr_sel | output | 16 | Task register selector |
| tr_base | output | ADDR_W | Task register base |
| tr_limit | output | 32 | Task register byte limit |

## Verification
A controller stuck in the wrong state shows up within the same load. It appears either as a missing `done` or `fault` pulse, or as a memory request that outlives its acknowledge. A wrong ordering of checks shows up as the wrong `fault_kind` on the next load that breaks two rules at once. An early lock release or a lost busy bit shows up as an unlocked write, or as an unchanged descriptor word read back after success. A wrongly assembled base or limit is visible in `tr_base` and `tr_limit` in the cycle `done` is high.

// File: rtl/trl_pkg.sv
package trl_pkg;
    typedef enum logic [2:0] {
        ST_IDLE, ST_RD_LO, ST_RD_HI, ST_EVAL, ST_WRITE, ST_DONE, ST_FAULT
    } trl_state_e;

    localparam logic [1:0] FK_NONE    = 2'd0;
    localparam logic [1:0] FK_GP_ZERO = 2'd1;
    localparam logic [1:0] FK_GP_SEL  = 2'd2;
    localparam logic [1:0] FK_NP_SEL  = 2'd3;

    localparam int        WORD_W     = 64;
    localparam int        BUSY_BIT   = 41;
    localparam logic [3:0] TSS_FREE16 = 4'd1;
    localparam logic [3:0] TSS_FREE32 = 4'd9;
endpackage

// File: rtl/trl_precheck.sv
module trl_precheck
    import trl_pkg::*;
#(
    parameter int TLIM_W = 16
) (
    input  logic [1:0]        cpl,
    input  logic [15:0]       sel,
    input  logic              long_mode,
    input  logic [TLIM_W-1:0] tbl_limit,
    output logic              pre_fault,
    output logic [1:0]        pre_kind
);
    localparam int OFF_W = ((TLIM_W > 16) ? TLIM_W : 16) + 1;

    logic [OFF_W-1:0] last_byte;
    logic             out_of_table;

    always_comb begin
        last_byte    = OFF_W'({sel[15:3], 3'b000}) + (long_mode ? OFF_W'(15) : OFF_W'(7));
        out_of_table = sel[2] || (last_byte > OFF_W'(tbl_limit));
        pre_fault    = 1'b1;
        pre_kind     = FK_GP_ZERO;
        if (cpl != 2'd0) begin
            pre_kind = FK_GP_ZERO;
        end else if (sel[15:2] == 14'd0) begin
            pre_kind = FK_GP_ZERO;
        end else if (out_of_table) begin
            pre_kind = FK_GP_SEL;
        end else begin
            pre_fault = 1'b0;
            pre_kind  = FK_NONE;
        end
    end
endmodule

// File: rtl/trl_desc_eval.sv
module trl_desc_eval
    import trl_pkg::*;
#(
    parameter int ADDR_W = 64
) (
    input  logic [WORD_W-1:0] d_lo,
    input  logic [WORD_W-1:0] d_hi,
    input  logic              long_mode,
    output logic              bad_type,
    output logic              not_present,
    output logic [WORD_W-1:0] busy_word,
    output logic [ADDR_W-1:0] base,
    output logic [31:0]       limit
);
    logic [3:0]  kind;
    logic [19:0] raw_lim;
    logic [63:0] full_base;

    always_comb begin
        kind        = d_lo[43:40];
        bad_type    = d_lo[44] || !((kind == TSS_FREE32) ||
                                     ((kind == TSS_FREE16) && !long_mode));
        not_present = !d_lo[47];
        busy_word   = d_lo;
        busy_word[BUSY_BIT] = 1'b1;
        raw_lim     = {d_lo[51:48], d_lo[15:0]};
        limit       = d_lo[55] ? {raw_lim, 12'hFFF} : {12'd0, raw_lim};
        full_base   = {(long_mode ? d_hi[31:0] : 32'd0), d_lo[63:56], d_lo[39:16]};
        base        = full_base[ADDR_W-1:0];
    end
endmodule

// File: rtl/trl_loader.sv
module trl_loader
    import trl_pkg::*;
#(
    parameter int ADDR_W = 64,
    parameter int TLIM_W = 16
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              start,
    input  logic [15:0]       sel_in,
    input  logic [1:0]        cpl,
    input  logic              long_mode,
    input  logic [ADDR_W-1:0] gdt_base,
    input  logic [TLIM_W-1:0] gdt_limit,
    output logic              mem_req,
    output logic              mem_we,
    output logic              mem_lock,
    output logic [ADDR_W-1:0] mem_addr,
    output logic [63:0]       mem_wdata,
    input  logic [63:0]       mem_rdata,
    input  logic              mem_ack,
    output logic              done,
    output logic              fault,
    output logic [1:0]        fault_kind,
    output logic [15:0]       err_code,
    output logic [15:0]       tr_sel,
    output logic [ADDR_W-1:0] tr_base,
    output logic [31:0]       tr_limit
);
    localparam logic [ADDR_W-1:0] HI_STEP = ADDR_W'(8);

    trl_state_e        state, nxt;
    logic [15:0]       sel_q;
    logic              long_q;
    logic [ADDR_W-1:0] addr_q;
    logic [63:0]       d_lo, d_hi;
    logic [1:0]        kind_q;
    logic [15:0]       code_q;

    logic              pre_fault;
    logic [1:0]        pre_kind;
    logic              bad_type, not_present;
    logic [63:0]       busy_word;
    logic [ADDR_W-1:0] desc_base;
    logic [31:0]       desc_limit;

    trl_precheck #(.TLIM_W(TLIM_W)) u_pre (
        .cpl(cpl), .sel(sel_in), .long_mode(long_mode), .tbl_limit(gdt_limit),
        .pre_fault(pre_fault), .pre_kind(pre_kind)
    );

    trl_desc_eval #(.ADDR_W(ADDR_W)) u_eval (
        .d_lo(d_lo), .d_hi(d_hi), .long_mode(long_q),
        .bad_type(bad_type), .not_present(not_present), .busy_word(busy_word),
        .base(desc_base), .limit(desc_limit)
    );

    // state register
    always_ff @(posedge clk) begin
        if (!rst_n) state <= ST_IDLE;
        else        state <= nxt;
    end

    always_comb begin
        nxt = state;
        unique case (state)
            ST_IDLE:  if (start) nxt = pre_fault ? ST_FAULT : ST_RD_LO;
            ST_RD_LO: if (mem_ack) nxt = long_q ? ST_RD_HI : ST_EVAL;
            ST_RD_HI: if (mem_ack) nxt = ST_EVAL;
            ST_EVAL:  nxt = (bad_type || not_present) ? ST_FAULT : ST_WRITE;
            ST_WRITE: if (mem_ack) nxt = ST_DONE;
            ST_DONE:  nxt = ST_IDLE;
            ST_FAULT: nxt = ST_IDLE;
            default:  nxt = ST_IDLE;
        endcase
    end

    // datapath registers
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            sel_q    <= '0;
            long_q   <= 1'b0;
            addr_q   <= '0;
            d_lo     <= '0;
            d_hi     <= '0;
            kind_q   <= FK_NONE;
            code_q   <= '0;
            tr_sel   <= '0;
            tr_base  <= '0;
            tr_limit <= '0;
        end else begin
            if (state == ST_IDLE && start) begin
                sel_q  <= sel_in;
                long_q <= long_mode;
                addr_q <= gdt_base + ADDR_W'({sel_in[15:3], 3'b000});
                d_lo   <= '0;
                d_hi   <= '0;
                kind_q <= pre_kind;
                code_q <= (pre_kind == FK_GP_SEL) ? {sel_in[15:2], 2'b00} : 16'd0;
            end
            if (state == ST_RD_LO && mem_ack) d_lo <= mem_rdata;
            if (state == ST_RD_HI && mem_ack) d_hi <= mem_rdata;
            if (state == ST_EVAL) begin
                kind_q <= bad_type ? FK_GP_SEL : (not_present ? FK_NP_SEL : FK_NONE);
                code_q <= {sel_q[15:2], 2'b00};
            end
            if (state == ST_WRITE && mem_ack) begin
                tr_sel   <= sel_q;
                tr_base  <= desc_base;
                tr_limit <= desc_limit;
            end
        end
    end

    // outputs
    always_comb begin
        mem_req    = 1'b0;
        mem_we     = 1'b0;
        mem_lock   = 1'b0;
        mem_addr   = addr_q;
        mem_wdata  = busy_word;
        done       = 1'b0;
        fault      = 1'b0;
        unique case (state)
            ST_RD_LO: begin mem_req = 1'b1; mem_lock = 1'b1; end
            ST_RD_HI: begin mem_req = 1'b1; mem_lock = 1'b1; mem_addr = addr_q + HI_STEP; end
            ST_EVAL:  mem_lock = 1'b1;
            ST_WRITE: begin mem_req = 1'b1; mem_we = 1'b1; mem_lock = 1'b1; end
            ST_DONE:  done = 1'b1;
            ST_FAULT: fault = 1'b1;
            default:  ;
        endcase
        fault_kind = kind_q;
        err_code   = code_q;
    end

    AST_WE_UNDER_LOCK: assert property (@(posedge clk) disable iff (!rst_n)
        mem_we |-> mem_lock); // R7
    AST_REQ_HELD: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_req && !mem_ack) |=> (mem_req && $stable(mem_addr) && $stable(mem_we))); // R7
    AST_WRITE_MARKS_BUSY: assert property (@(posedge clk) disable iff (!rst_n)
        mem_we |-> mem_wdata[BUSY_BIT]); // R7
    AST_PRIV_FIRST: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_IDLE && start && cpl != 2'd0) |=> (fault && fault_kind == FK_GP_ZERO && !mem_req)); // R2
    AST_DONE_AFTER_WRITE: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> $past(mem_we && mem_ack)); // R9
    AST_FAULT_UNLOCKED: assert property (@(posedge clk) disable iff (!rst_n)
        fault |-> (!mem_lock && !mem_req && fault_kind != FK_NONE)); // R10
    AST_ONE_OUTCOME: assert property (@(posedge clk) disable iff (!rst_n)
        !(done && fault)); // R10
    AST_TR_KEPT_ON_FAULT: assert property (@(posedge clk) disable iff (!rst_n)
        fault |-> ($stable(tr_sel) && $stable(tr_limit))); // R10
endmodule

// File: tb/sim_trl_loader.sv
module sim_trl_loader;
    logic        clk = 1'b0;
    logic        rst_n;
    logic        start;
    logic [15:0] sel_in;
    logic [1:0]  cpl;
    logic        long_mode;
    logic [63:0] gdt_base;
    logic [15:0] gdt_limit;
    logic        mem_req, mem_we, mem_lock;
    logic [63:0] mem_addr, mem_wdata;
    logic [63:0] mem_rdata;
    logic        mem_ack;
    logic        done, fault;
    logic [1:0]  fault_kind;
    logic [15:0] err_code, tr_sel;
    logic [63:0] tr_base;
    logic [31:0] tr_limit;

    int checks = 0;
    int errors = 0;
    int req_cycles = 0;
    int lock_viol = 0;
    logic [63:0] dmem [0:31];

    always #4 clk = ~clk;

    trl_loader u0 (
        .clk(clk), .rst_n(rst_n), .start(start), .sel_in(sel_in), .cpl(cpl),
        .long_mode(long_mode), .gdt_base(gdt_base), .gdt_limit(gdt_limit),
        .mem_req(mem_req), .mem_we(mem_we), .mem_lock(mem_lock), .mem_addr(mem_addr),
        .mem_wdata(mem_wdata), .mem_rdata(mem_rdata), .mem_ack(mem_ack),
        .done(done), .fault(fault), .fault_kind(fault_kind), .err_code(err_code),
        .tr_sel(tr_sel), .tr_base(tr_base), .tr_limit(tr_limit)
    );

    // memory responder: acknowledge one cycle after a request
    always @(posedge clk) begin
        if (!rst_n) begin
            mem_ack   <= 1'b0;
            mem_rdata <= '0;
        end else begin
            mem_ack <= mem_req && !mem_ack;
            if (mem_req && !mem_ack) begin
                mem_rdata <= dmem[mem_addr[7:3]];
                if (mem_we) dmem[mem_addr[7:3]] <= mem_wdata;
            end
        end
    end

    always @(posedge clk) begin
        if (mem_req) req_cycles <= req_cycles + 1;
        if (mem_we && !mem_lock) lock_viol <= lock_viol + 1;
    end

    task automatic check(input bit ok, input string req, input string what,
                         input logic [63:0] act, input logic [63:0] exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s %s actual=%h expected=%h", req, what, act, exp);
        end
    endtask

    function automatic logic [63:0] mk_lo(input logic [31:0] b, input logic [19:0] l,
                                          input logic [3:0] t, input bit s, input bit p, input bit g);
        return {b[31:24], g, 3'b000, l[19:16], p, 2'b00, s, t, b[23:0], l[15:0]};
    endfunction

    task automatic put_desc(input int idx, input logic [63:0] lo, input logic [63:0] hi);
        dmem[idx]     <= lo;
        dmem[idx + 1] <= hi;
        @(negedge clk);
    endtask

    task automatic run_op(input logic [1:0] c, input logic [15:0] s, input bit lm,
                          input logic [15:0] lim);
        int idx = int'(s[7:3]);
        logic [63:0] lo = dmem[idx];
        logic [63:0] hi = dmem[(idx + 1) % 32];
        logic [1:0]  ekind;
        logic [15:0] ecode;
        bit          pre;
        string       rq;
        logic [63:0] ebase;
        logic [31:0] elim;
        logic [15:0] old_sel = tr_sel;
        logic [63:0] old_base = tr_base;
        logic [31:0] old_lim = tr_limit;
        int          req0;
        int          n = 0;
        logic [3:0]  t = lo[43:40];
        ekind = 2'd0; ecode = 16'd0; pre = 1'b0; rq = "R9";
        if (c != 2'd0) begin
            ekind = 2'd1; pre = 1'b1; rq = "R2";
        end else if (s[15:2] == 14'd0) begin
            ekind = 2'd1; pre = 1'b1; rq = "R3";
        end else if (s[2] || (32'({s[15:3], 3'b000}) + (lm ? 32'd15 : 32'd7) > 32'(lim))) begin
            ekind = 2'd2; ecode = {s[15:2], 2'b00}; pre = 1'b1; rq = "R4";
        end else if (lo[44] || !(t == 4'd9 || (t == 4'd1 && !lm))) begin
            ekind = 2'd2; ecode = {s[15:2], 2'b00}; rq = "R5";
        end else if (!lo[47]) begin
            ekind = 2'd3; ecode = {s[15:2], 2'b00}; rq = "R6";
        end
        ebase = {(lm ? hi[31:0] : 32'd0), lo[63:56], lo[39:16]};
        elim  = lo[55] ? {lo[51:48], lo[15:0], 12'hFFF} : {12'd0, lo[51:48], lo[15:0]};

        req0 = req_cycles;
        cpl = c; sel_in = s; long_mode = lm; gdt_limit = lim; start = 1'b1;
        @(negedge clk);
        start = 1'b0;
        while (!(done || fault) && n < 200) begin
            @(negedge clk);
            n++;
        end
        if (n >= 200) begin
            check(1'b0, rq, "watchdog: no outcome", 64'd0, 64'd1);
            return;
        end
        if (ekind == 2'd0) begin
            check(done && !fault, "R9", "done pulse", {62'd0, done, fault}, 64'd2);
            check(tr_sel == s, "R9", "tr_sel", 64'(tr_sel), 64'(s));
            check(tr_base == ebase, "R8", "tr_base", tr_base, ebase);
            check(tr_limit == elim, "R9", "tr_limit", 64'(tr_limit), 64'(elim));
            @(negedge clk);
            check(dmem[idx] == (lo | 64'h0000_0200_0000_0000), "R7", "busy write-back",
                  dmem[idx], lo | 64'h0000_0200_0000_0000);
        end else begin
            check(fault && !done && fault_kind == ekind, rq, "fault kind",
                  {fault, done, 60'd0, fault_kind}, {2'b10, 60'd0, ekind});
            check(err_code == ecode, rq, "error code", 64'(err_code), 64'(ecode));
            check(tr_sel == old_sel && tr_base == old_base && tr_limit == old_lim, "R10",
                  "task register kept", 64'(tr_sel), 64'(old_sel));
            if (pre)
                check(req_cycles == req0, rq, "no memory access", 64'(req_cycles - req0), 64'd0);
            else
                check(dmem[idx] == lo, rq, "descriptor unchanged", dmem[idx], lo);
            @(negedge clk);
        end
        check(!done && !fault, "R10", "single-cycle outcome", {62'd0, done, fault}, 64'd0);
        check(lock_viol == 0, "R7", "writes under lock", 64'(lock_viol), 64'd0);
    endtask

    initial begin
        void'($urandom(32'h5EED_0042));
        rst_n = 1'b0; start = 1'b0; sel_in = '0; cpl = '0; long_mode = 1'b0;
        gdt_base = '0; gdt_limit = '0;
        for (int i = 0; i < 32; i++) dmem[i] <= '0;
        repeat (3) @(negedge clk);
        check(!done && !fault && !mem_req && !mem_we && !mem_lock, "R1", "idle outputs",
              {59'd0, done, fault, mem_req, mem_we, mem_lock}, 64'd0);
        check(tr_sel == 0 && tr_base == 0 && tr_limit == 0, "R1", "task register zero",
              tr_base, 64'd0);
        rst_n = 1'b1;
        @(negedge clk);

        // directed corner cases
        put_desc(2, mk_lo(32'h1234_5678, 20'h00067, 4'd9, 1'b0, 1'b1, 1'b0), 64'hAAAA_BBBB_CCCC_DDDD);
        run_op(2'd3, 16'h0010, 1'b0, 16'hFFFF);          // R2 privilege
        run_op(2'd0, 16'h0003, 1'b0, 16'hFFFF);          // R3 null with RPL
        run_op(2'd1, 16'h0000, 1'b0, 16'h0000);          // R2 beats R3
        run_op(2'd0, 16'h0014, 1'b0, 16'hFFFF);          // R4 local table
        run_op(2'd0, 16'h0010, 1'b0, 16'd22);            // R4 one byte short
        run_op(2'd0, 16'h0010, 1'b1, 16'd30);            // R4 long mode needs 16 bytes
        run_op(2'd0, 16'h0013, 1'b0, 16'd23);            // R9 exact bound, RPL kept
        run_op(2'd0, 16'h0010, 1'b0, 16'hFFFF);          // R5 now busy (11)
        put_desc(4, mk_lo(32'h8765_4321, 20'hABCDE, 4'd9, 1'b0, 1'b1, 1'b1), 64'h0000_0000_FEED_F00D);
        run_op(2'd0, 16'h0020, 1'b1, 16'd47);            // R8 long base, G scaling
        put_desc(6, mk_lo(32'h0000_1000, 20'h00FFF, 4'd1, 1'b0, 1'b1, 1'b0), 64'h1);
        run_op(2'd0, 16'h0030, 1'b1, 16'hFFFF);          // R5 16-bit kind in long mode
        run_op(2'd0, 16'h0030, 1'b0, 16'hFFFF);          // R9 16-bit kind legacy -> 3
        put_desc(8, mk_lo(32'h0, 20'h1, 4'd9, 1'b1, 1'b1, 1'b0), 64'h0);
        run_op(2'd0, 16'h0040, 1'b0, 16'hFFFF);          // R5 code/data descriptor
        put_desc(10, mk_lo(32'h0, 20'h1, 4'd9, 1'b0, 1'b0, 1'b0), 64'h0);
        run_op(2'd0, 16'h0050, 1'b0, 16'hFFFF);          // R6 not present
        put_desc(12, mk_lo(32'h0, 20'h1, 4'd3, 1'b0, 1'b0, 1'b0), 64'h0);
        run_op(2'd0, 16'h0060, 1'b0, 16'hFFFF);          // R5 before R6

        // constrained random
        for (int k = 0; k < 80; k++) begin
            int          idx = 1 + int'($urandom % 14);
            logic [3:0]  tsel[6] = '{4'd1, 4'd9, 4'd9, 4'd3, 4'd11, 4'd2};
            logic [3:0]  t = ($urandom % 5 == 0) ? 4'($urandom) : tsel[$urandom % 6];
            logic [15:0] s = {8'd0, 5'(idx), 1'($urandom % 8 == 0), 2'($urandom)};
            logic [1:0]  c = ($urandom % 6 == 0) ? 2'(1 + $urandom % 3) : 2'd0;
            put_desc(idx, mk_lo($urandom, 20'($urandom), t, 1'($urandom % 8 == 0),
                                1'($urandom % 6 != 0), 1'($urandom)),
                     {$urandom, $urandom});
            run_op(c, ($urandom % 20 == 0) ? 16'h0002 : s, 1'($urandom),
                   ($urandom % 3 == 0) ? 16'($urandom % 256) : 16'hFFFF);
        end

        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        repeat (150000) @(posedge clk);
        errors++;
        checks++;
        $display("FAIL watchdog expired R10 actual=running expected=finished");
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule